// File: doc/BRIEF.md
# Multi-format serial audio input receiver

This block receives stereo PCM audio as a slave on three lines: a bit clock, a word-select line and a serial data line. It runs entirely on the bit clock. Left and right words share the data line in turn, and the level of word select tells which channel is on the line. A 3-bit format code chooses among five framings. In I2S the word starts one bit clock after the word-select change. In MSB-justified it starts on the same bit clock. In the three LSB-justified framings the word ends on the last bit before the next change. Each completed word is put out at a fixed width of 20 bits. Framings that send the MSB first are left-aligned and zero-padded. LSB-justified words are sign-extended.

A single shift engine covers both MSB-first alignments. I2S is handled by moving the word boundary one bit clock later, which lets both alignments share the same capture point. A separate 20-bit history window serves the LSB-justified framings: it is read at the word-select edge and sign-extended from 16, 18 or 20 bits. When a right word completes, the block gives a one-cycle frame strobe. The left and right outputs are then a matched pair from the same frame.

Top module: `pcm_serial_rx`

## Requirements
- R1: With format code 000 (I2S), the MSB is the data bit sampled on the second rising bit-clock edge after a word-select change. The word is placed MSB-first from bit 19 downward, and positions not carried by the word read zero.
- R2: With format code 100 (MSB-justified), the MSB is the bit sampled on the first rising edge after a word-select change. A word shorter than 20 bits appears left-aligned, with zeros in the unused low bits.
- R3: With format code 001, the 16 bits sampled just before a word-select edge form the word, with its last bit as LSB. The output is that word sign-extended from bit 15 to 20 bits.
- R4: With format code 010, the 18 bits sampled just before the edge form the word. The output is that word sign-extended from bit 17.
- R5: With format code 011, the 20 bits sampled just before the edge are put out unchanged. Bits sent earlier in the slot have no effect.
- R6: In I2S and MSB-justified modes, data bits after the 20th bit of a word have no effect on the output.
- R7: A word sent while word select is low appears on the left output, and a word sent while it is high appears on the right output. The left output holds its value while the frame strobe is high.
- R8: The frame strobe is high for exactly one bit-clock cycle per frame. It rises on the bit-clock edge that follows the rising edge at which the right word completes: the word-select edge itself in MSB-justified and LSB-justified modes, and one bit clock later in I2S. The right output carries the new word while the strobe is high.
- R9: Format codes 101, 110 and 111 produce no frame strobe and leave both outputs unchanged.
- R10: While reset is low, both outputs are zero and the strobe is low. After reset, a slot that was already in progress is discarded. The first strobe comes from the first full left-then-right frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; data and word select are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ws | input | 1 | Word select; low = left channel, high = right channel |
| sd | input | 1 | Serial audio data, MSB first |
| fmt | input | 3 | Framing code: 000 I2S, 001/010/011 LSB-justified 16/18/20, 100 MSB-justified |
| smp_left | output | WORD_W (20) | Last completed left word |
| smp_right | output | WORD_W (20) | Last completed right word |
| frame_vld | output | 1 | One-cycle strobe after each right word is captured |

## Verification
The assertions assume that word select and data change only on falling bit-clock edges. They also assume that the format code changes only between frames, while no word is completing. In I2S and MSB-justified modes, each slot must be at least 21 bit clocks long, so that the edge-cycle bit of an I2S word lies beyond the 20th position. The stimulus keeps within these limits. It drives every line on the falling edge and runs slots of 24 and 32 bit clocks. Before it changes the format code, it either resets the block or sends a short idle tail, so the last word of one format is never judged under another.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   typedef enum logic [2:0] {
      FMT_I2S   = 3'd0,
      FMT_RJ16  = 3'd1,
      FMT_RJ18  = 3'd2,
      FMT_RJ20  = 3'd3,
      FMT_LEFTJ = 3'd4
   } fmt_e;

   function automatic logic fmt_known(input logic [2:0] f);
      return f <= 3'd4;
   endfunction

   function automatic logic fmt_rjust(input logic [2:0] f);
      return (f == 3'd1) || (f == 3'd2) || (f == 3'd3);
   endfunction

endpackage

// File: rtl/pcm_rx_edge.sv
module pcm_rx_edge
   import pcm_rx_pkg::*;
(
   input  logic       bclk,
   input  logic       rst_n,
   input  logic       ws,
   input  logic [2:0] fmt,
   output logic       strobe,
   output logic       done_ch,
   output logic       armed
);

   logic ws_d, ws_dd;
   logic late;

   always_comb begin
      late    = (fmt == FMT_I2S);
      strobe  = late ? (ws_d ^ ws_dd) : (ws ^ ws_d);
      done_ch = late ? ws_dd : ws_d;
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         ws_d  <= 1'b0;
         ws_dd <= 1'b0;
         armed <= 1'b0;
      end else begin
         ws_d  <= ws;
         ws_dd <= ws_d;
         if (strobe && done_ch) armed <= 1'b1;
      end
   end

   // R10
   arm_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      armed |=> armed);

endmodule

// File: rtl/pcm_rx_msbacc.sv
module pcm_rx_msbacc #(
   parameter int WORD_W = 20
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              sd,
   output logic [WORD_W-1:0] word
);

   localparam logic [WORD_W-1:0] W_ONE = WORD_W'(1);

   logic [WORD_W-1:0] acc_q, pos_q;

   if (WORD_W < 3) begin : g_width_bad
      $error("pcm_rx_msbacc: WORD_W must be at least 3");
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         pos_q <= '0;
      end else if (restart) begin
         acc_q <= (W_ONE << (WORD_W - 1)) & {WORD_W{sd}};
         pos_q <= W_ONE << (WORD_W - 2);
      end else begin
         if (sd) acc_q <= acc_q | pos_q;
         pos_q <= pos_q >> 1;
      end
   end

   assign word = acc_q;

   // R6
   pos_onehot_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      $onehot0(pos_q));

   // R6
   pos_drain_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (!restart && pos_q == '0) |=> $stable(acc_q));

endmodule

// File: rtl/pcm_rx_rjwin.sv
module pcm_rx_rjwin #(
   parameter int WORD_W  = 20,
   parameter int NUM_LEN = 3,
   parameter int LEN [NUM_LEN] = '{16, 18, 20}
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              sd,
   output logic [WORD_W-1:0] cand [NUM_LEN]
);

   logic [WORD_W-1:0] hist_q;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) hist_q <= '0;
      else        hist_q <= {hist_q[WORD_W-2:0], sd};
   end

   for (genvar i = 0; i < NUM_LEN; i++) begin : g_len
      if (LEN[i] < 2 || LEN[i] > WORD_W) begin : g_bad
         $error("pcm_rx_rjwin: word length out of range");
      end else if (LEN[i] == WORD_W) begin : g_full
         assign cand[i] = hist_q;
      end else begin : g_ext
         assign cand[i] = {{(WORD_W - LEN[i]){hist_q[LEN[i]-1]}}, hist_q[LEN[i]-1:0]};
      end
   end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcm_rx_pkg::*;
#(
   parameter int WORD_W   = 20,
   parameter int RJ_SHORT = 16,
   parameter int RJ_MID   = 18,
   parameter int RJ_LONG  = 20
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              ws,
   input  logic              sd,
   input  logic [2:0]        fmt,
   output logic [WORD_W-1:0] smp_left,
   output logic [WORD_W-1:0] smp_right,
   output logic              frame_vld
);

   localparam int NUM_RJ = 3;
   localparam int RJ_LEN [NUM_RJ] = '{RJ_SHORT, RJ_MID, RJ_LONG};

   if (RJ_LONG > WORD_W || RJ_SHORT > RJ_MID || RJ_MID > RJ_LONG) begin : g_cfg_bad
      $error("pcm_serial_rx: right-justified lengths must rise and fit WORD_W");
   end

   logic              strobe, done_ch, armed;
   logic [WORD_W-1:0] msb_word;
   logic [WORD_W-1:0] rj_cand [NUM_RJ];
   logic [WORD_W-1:0] word_in;
   logic              cap_en;

   pcm_rx_edge u_edge (
      .bclk    (bclk),
      .rst_n   (rst_n),
      .ws      (ws),
      .fmt     (fmt),
      .strobe  (strobe),
      .done_ch (done_ch),
      .armed   (armed)
   );

   pcm_rx_msbacc #(.WORD_W(WORD_W)) u_acc (
      .bclk    (bclk),
      .rst_n   (rst_n),
      .restart (strobe),
      .sd      (sd),
      .word    (msb_word)
   );

   pcm_rx_rjwin #(.WORD_W(WORD_W), .NUM_LEN(NUM_RJ), .LEN(RJ_LEN)) u_win (
      .bclk  (bclk),
      .rst_n (rst_n),
      .sd    (sd),
      .cand  (rj_cand)
   );

   always_comb begin
      unique case (fmt)
         FMT_RJ16: word_in = rj_cand[0];
         FMT_RJ18: word_in = rj_cand[1];
         FMT_RJ20: word_in = rj_cand[2];
         default:  word_in = msb_word;
      endcase
      cap_en = strobe && armed && fmt_known(fmt);
   end

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         smp_left  <= '0;
         smp_right <= '0;
         frame_vld <= 1'b0;
      end else begin
         frame_vld <= 1'b0;
         if (cap_en) begin
            if (!done_ch) begin
               smp_left <= word_in;
            end else begin
               smp_right <= word_in;
               frame_vld <= 1'b1;
            end
         end
      end
   end

   // R8
   vld_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      frame_vld |=> !frame_vld);

   // R7
   left_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      frame_vld |-> $stable(smp_left));

   // R9
   unused_quiet_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      (fmt > 3'd4) |=> (!frame_vld && $stable(smp_left) && $stable(smp_right)));

   // R10
   unarmed_quiet_chk: assert property (@(posedge bclk) disable iff (!rst_n)
      !armed |=> !frame_vld);

endmodule

// File: tb/pcm_serial_rx_bench.sv
module pcm_serial_rx_bench;

   typedef struct {
      logic [19:0] l;
      logic [19:0] r;
      string       tag;
   } exp_t;

   logic        bclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ws = 1'b1;
   logic        sd = 1'b0;
   logic [2:0]  fmt = 3'd4;
   logic [19:0] smp_left, smp_right;
   logic        frame_vld;

   int   checks = 0;
   int   errors = 0;
   int   pushed = 0;
   int   vld_seen = 0;
   exp_t q[$];

   always #10 bclk = ~bclk;

   pcm_serial_rx u_pcm_serial_rx (
      .bclk      (bclk),
      .rst_n     (rst_n),
      .ws        (ws),
      .sd        (sd),
      .fmt       (fmt),
      .smp_left  (smp_left),
      .smp_right (smp_right),
      .frame_vld (frame_vld)
   );

   task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int rj_len(input logic [2:0] f);
      return (f == 3'd1) ? 16 : (f == 3'd2) ? 18 : 20;
   endfunction

   function automatic logic [19:0] exp_word(input logic [2:0] f, input int wlen, input logic [31:0] w);
      logic [19:0] r;
      if (f == 3'd1 || f == 3'd2 || f == 3'd3) begin
         for (int i = 0; i < 20; i++) r[i] = (i < rj_len(f)) ? w[i] : w[rj_len(f)-1];
      end else begin
         for (int i = 0; i < 20; i++) r[i] = ((19 - i) < wlen) ? w[wlen-1-(19-i)] : 1'b0;
      end
      return r;
   endfunction

   function automatic logic bit_at(input logic [2:0] f, input int wlen, input int slot,
                                   input logic [31:0] w, input int p);
      int k, st;
      if (f == 3'd1 || f == 3'd2 || f == 3'd3) begin
         st = slot - rj_len(f);
         if (p < st) return (p % 3 == 0);
         return w[rj_len(f)-1-(p-st)];
      end
      k = (f == 3'd0) ? p - 1 : p;
      if (k < 0)    return 1'b1;
      if (k < wlen) return w[wlen-1-k];
      if (k < 20)   return 1'b0;
      return 1'b1;
   endfunction

   task automatic drive_bit(input logic w, input logic d);
      @(negedge bclk);
      ws = w;
      sd = d;
   endtask

   task automatic send_frame(input string tag, input int wlen, input int slot,
                             input logic [31:0] lw, input logic [31:0] rw, input bit expect_out);
      exp_t e;
      if (expect_out) begin
         e.l = exp_word(fmt, wlen, lw);
         e.r = exp_word(fmt, wlen, rw);
         e.tag = tag;
         q.push_back(e);
         pushed++;
      end
      for (int ch = 0; ch < 2; ch++)
         for (int p = 0; p < slot; p++)
            drive_bit(ch[0], bit_at(fmt, wlen, slot, (ch == 0) ? lw : rw, p));
   endtask

   task automatic close_section(input string tag);
      for (int i = 0; i < 4; i++) drive_bit(1'b0, 1'b0);
      repeat (4) @(negedge bclk);
      chk({tag, " R8 pending words"}, 20'(q.size()), 20'd0);
      chk({tag, " R8 strobe count"}, 20'(vld_seen), 20'(pushed));
   endtask

   task automatic restart(input logic [2:0] f);
      @(negedge bclk);
      rst_n = 1'b0;
      ws = 1'b1;
      sd = 1'b0;
      fmt = f;
      repeat (3) @(negedge bclk);
      chk("R10 left in reset", smp_left, 20'd0);
      chk("R10 right in reset", smp_right, 20'd0);
      chk("R10 strobe in reset", 20'(frame_vld), 20'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) drive_bit(1'b1, (i % 2 == 0));
   endtask

   // scoreboard monitor
   always @(negedge bclk) begin
      if (rst_n && frame_vld) begin
         vld_seen++;
         if (q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R9 unexpected strobe actual=1 expected=0");
         end else begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " R7 left"}, smp_left, e.l);
            chk({e.tag, " R7 right"}, smp_right, e.r);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge bclk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [19:0] keep_l, keep_r;
      int          seen_before;

      // MSB-justified
      restart(3'd4);
      send_frame("R2 msb 20b", 20, 32, 32'h000A5C3E, 32'h0001B2D4, 1'b1);
      send_frame("R2 msb 16b", 16, 32, 32'h00008001, 32'h00007FFE, 1'b1);
      send_frame("R6 msb 24b", 24, 32, 32'h00F0F0F3, 32'h00123456, 1'b1);
      send_frame("R2 msb slot24", 20, 24, 32'h00054321, 32'h000FEDCB, 1'b1);
      close_section("msb");

      // unused codes leave outputs alone
      keep_l = smp_left;
      keep_r = smp_right;
      seen_before = vld_seen;
      fmt = 3'd5;
      send_frame("R9 code5", 20, 32, 32'h00011111, 32'h00022222, 1'b0);
      fmt = 3'd7;
      send_frame("R9 code7", 20, 32, 32'h00033333, 32'h00044444, 1'b0);
      for (int i = 0; i < 4; i++) drive_bit(1'b1, 1'b1);
      for (int i = 0; i < 4; i++) drive_bit(1'b0, 1'b0);
      repeat (3) @(negedge bclk);
      chk("R9 left held", smp_left, keep_l);
      chk("R9 right held", smp_right, keep_r);
      chk("R9 no strobe", 20'(vld_seen - seen_before), 20'd0);

      // I2S
      restart(3'd0);
      send_frame("R1 i2s 20b", 20, 32, 32'h000C3A5F, 32'h00012345, 1'b1);
      send_frame("R1 i2s 16b", 16, 32, 32'h0000FFFF, 32'h00000001, 1'b1);
      send_frame("R6 i2s 24b", 24, 32, 32'h00ABCDEF, 32'h00FEDCBA, 1'b1);
      send_frame("R1 i2s slot24", 20, 24, 32'h00080001, 32'h0007FFFE, 1'b1);
      close_section("i2s");

      // LSB-justified 16
      restart(3'd1);
      send_frame("R3 rj16 neg/pos", 16, 32, 32'h00008123, 32'h00007ABC, 1'b1);
      send_frame("R3 rj16 pos/neg", 16, 24, 32'h00000042, 32'h0000FFFF, 1'b1);
      close_section("rj16");

      // LSB-justified 18
      restart(3'd2);
      send_frame("R4 rj18 neg/pos", 18, 32, 32'h00020001, 32'h0001FFFF, 1'b1);
      send_frame("R4 rj18 slot24", 18, 24, 32'h00015555, 32'h0002AAAA, 1'b1);
      close_section("rj18");

      // LSB-justified 20
      restart(3'd3);
      send_frame("R5 rj20", 20, 32, 32'h00080000, 32'h0007FFFF, 1'b1);
      send_frame("R5 rj20 slot24", 20, 24, 32'h000A0A0A, 32'h00050505, 1'b1);
      close_section("rj20");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule